// File: doc/BRIEF.md
# Shared Interrupt Line Controller

This block collects a parameterised set of external interrupt lines that several processor cores share. Every line passes through a two-stage synchronizer. It is then interpreted according to three per-line settings: an active-level choice, a level-or-edge choice, and a both-edges option. Edge events are held in a sticky per-line latch. A per-line enable mask gates each line, and each line is steered to exactly one core and, optionally, to one numbered request pin of that core.

Software programs the block through a simple 32-bit word-addressed register bus with a write strobe and a combinational read port. The mask is never written directly. One register turns enables on and a second turns them off, so concurrent agents cannot lose each other's updates. A single command register can either inject an edge event on a line or acknowledge it, which lets software use spare lines as inter-processor signals. A read-only capability word reports the line and core counts.

Top module: `shint_ctrl`

## Requirements
- R1: A write to the enable-on register (word 0x03) sets every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. The mask reads back at word 0x02.
- R2: A write to the enable-off register (word 0x04) clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R3: After reset, the following hold. The active-level word (0x05) reads all ones, meaning active high. The trigger word (0x06) reads 0, meaning level. The both-edges word (0x07) reads 0. The mask reads 0. Every line is routed to core 0 with its pin entry invalid. All core requests are low.
- R4: A level line (trigger bit 0) is pending while its synchronized input equals its active level: 1 when the active-level bit is 1, 0 when it is 0. The raw pending bitmap reads at word 0x01. An input change reaches the pending bit two clock edges after it is sampled.
- R5: An edge line (trigger bit 1, both-edges bit 0) latches pending on a synchronized rising transition when its active-level bit is 1, and on a falling transition when it is 0. Pending stays set until it is acknowledged.
- R6: On an edge line with both-edges bit 1, either transition latches pending, whatever the active-level bit holds.
- R7: A write to the edge command register (word 0x08) names a line in data bits [7:0]. Data bit 31 set to 1 forces that line's edge latch. Bit 31 set to 0 clears the latch. A line number at or above the line count is ignored. A transition detected on the same clock edge as a clear leaves the latch set.
- R8: Core request c is high exactly when some line routed to core c is both pending and enabled in the mask.
- R9: Writing word 0x40+i selects the single target core for line i from the low data bits, and the value reads back there. The line's request then leaves its previous core.
- R10: Writing word 0x80+i stores a pin number for line i and always marks the entry valid, even when data bit 31 is 0. The entry reads back with the valid flag in bit 31. Pin output c*2^PIN_W+p is high only for a valid entry with pin p, on a line routed to core c that is pending and enabled.
- R11: The capability word (0x00) holds line_count/8-1 in bits [7:0] and core_count-1 in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_irq | output | NUM_CORES | Per-core interrupt request |
| core_pin | output | NUM_CORES*2^PIN_W | Per-core, per-pin request lines |

## Verification
The sharpest collision is between a synchronized edge arriving on a line and a software acknowledge of that same line on the same clock edge. The bench provokes it by raising the input exactly two cycles before it presents the clear command, so both reach the latch together. It judges the outcome by reading the pending word afterwards and requiring the bit to remain set. A second overlap, re-routing a line while it is pending, is judged by the request moving between cores with no cycle in which both are high. A behavioural model checks both cases on every clock, and also during a randomised phase that mixes line toggles with configuration writes.

// File: rtl/shint_pkg.sv
package shint_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CAPS      = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND      = 8'h01;
    localparam logic [ADDR_W-1:0] A_MASK      = 8'h02;
    localparam logic [ADDR_W-1:0] A_MASK_ON   = 8'h03;
    localparam logic [ADDR_W-1:0] A_MASK_OFF  = 8'h04;
    localparam logic [ADDR_W-1:0] A_ACT_LVL   = 8'h05;
    localparam logic [ADDR_W-1:0] A_TRIG      = 8'h06;
    localparam logic [ADDR_W-1:0] A_BOTH      = 8'h07;
    localparam logic [ADDR_W-1:0] A_EDGE_CMD  = 8'h08;
    localparam logic [ADDR_W-1:0] A_CORE_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] A_PIN_BASE  = 8'h80;

    localparam int CMD_SET_BIT = 31;
    localparam int PIN_VLD_BIT = 31;
    localparam int CMD_LINE_W  = 8;

    typedef struct packed {
        logic both;
        logic edge_mode;
        logic act_high;
    } line_cfg_t;

    function automatic logic edge_seen(line_cfg_t c, logic now, logic prev);
        if (c.both)
            return now ^ prev;
        return c.act_high ? (now & ~prev) : (~now & prev);
    endfunction

    function automatic logic level_active(line_cfg_t c, logic now);
        return c.act_high ? now : ~now;
    endfunction

endpackage

// File: rtl/shint_sync.sv
module shint_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] st1, st2, st3;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
            st2 <= '0;
            st3 <= '0;
        end else begin
            st1 <= din;
            st2 <= st1;
            st3 <= st2;
        end
    end

    assign lvl  = st2;
    assign prev = st3;
endmodule

// File: rtl/shint_line.sv
module shint_line
    import shint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_cfg_t cfg,
    input  logic      lvl,
    input  logic      prev,
    input  logic      cmd_set,
    input  logic      cmd_clr,
    output logic      pend,
    output logic      edge_q
);
    logic det;

    assign det = cfg.edge_mode & edge_seen(cfg, lvl, prev);

    always_ff @(posedge clk) begin
        if (rst)
            edge_q <= 1'b0;
        else if (cmd_clr)
            edge_q <= det;
        else
            edge_q <= edge_q | det | cmd_set;
    end

    assign pend = cfg.edge_mode ? edge_q : level_active(cfg, lvl);
endmodule

// File: rtl/shint_regs.sv
module shint_regs
    import shint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CORES = 4,
    parameter int PIN_W     = 3,
    parameter int CORE_W    = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                bus_we,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [BUS_W-1:0]                    bus_wdata,
    output logic [BUS_W-1:0]                    bus_rdata,
    input  logic [NUM_LINES-1:0]                pend,
    output logic [NUM_LINES-1:0]                mask,
    output logic [NUM_LINES-1:0]                act_high,
    output logic [NUM_LINES-1:0]                edge_mode,
    output logic [NUM_LINES-1:0]                both,
    output logic [NUM_LINES-1:0][CORE_W-1:0]    core_sel,
    output logic [NUM_LINES-1:0][PIN_W-1:0]     pin_num,
    output logic [NUM_LINES-1:0]                pin_vld,
    output logic [NUM_LINES-1:0]                cmd_set,
    output logic [NUM_LINES-1:0]                cmd_clr
);
    localparam logic [7:0] LINE_FLD = 8'(NUM_LINES / 8 - 1);
    localparam logic [7:0] CORE_FLD = 8'(NUM_CORES - 1);

    logic                  edge_wr;
    logic [CMD_LINE_W-1:0] cmd_line;
    logic                  core_ok;
    logic                  unused_wbits;

    assign edge_wr      = bus_we && (bus_addr == A_EDGE_CMD);
    assign cmd_line     = bus_wdata[CMD_LINE_W-1:0];
    assign core_ok      = int'(bus_wdata[CORE_W-1:0]) < NUM_CORES;
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask      <= '0;
            act_high  <= '1;
            edge_mode <= '0;
            both      <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_MASK_ON:  mask      <= mask | bus_wdata[NUM_LINES-1:0];
                A_MASK_OFF: mask      <= mask & ~bus_wdata[NUM_LINES-1:0];
                A_ACT_LVL:  act_high  <= bus_wdata[NUM_LINES-1:0];
                A_TRIG:     edge_mode <= bus_wdata[NUM_LINES-1:0];
                A_BOTH:     both      <= bus_wdata[NUM_LINES-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_regs
        logic core_wr, pin_wr;

        assign core_wr = bus_we && (bus_addr == A_CORE_BASE + ADDR_W'(i));
        assign pin_wr  = bus_we && (bus_addr == A_PIN_BASE + ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                core_sel[i] <= '0;
                pin_num[i]  <= '0;
                pin_vld[i]  <= 1'b0;
            end else begin
                if (core_wr && core_ok)
                    core_sel[i] <= bus_wdata[CORE_W-1:0];
                if (pin_wr) begin
                    pin_num[i] <= bus_wdata[PIN_W-1:0];
                    pin_vld[i] <= 1'b1;
                end
            end
        end

        assign cmd_set[i] = edge_wr &&  bus_wdata[CMD_SET_BIT] && (cmd_line == CMD_LINE_W'(i));
        assign cmd_clr[i] = edge_wr && !bus_wdata[CMD_SET_BIT] && (cmd_line == CMD_LINE_W'(i));
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CAPS: begin
                bus_rdata[7:0]  = LINE_FLD;
                bus_rdata[15:8] = CORE_FLD;
            end
            A_PEND:    bus_rdata[NUM_LINES-1:0] = pend;
            A_MASK:    bus_rdata[NUM_LINES-1:0] = mask;
            A_ACT_LVL: bus_rdata[NUM_LINES-1:0] = act_high;
            A_TRIG:    bus_rdata[NUM_LINES-1:0] = edge_mode;
            A_BOTH:    bus_rdata[NUM_LINES-1:0] = both;
            default: ;
        endcase
        for (int i = 0; i < NUM_LINES; i++) begin
            if (bus_addr == A_CORE_BASE + ADDR_W'(i))
                bus_rdata[CORE_W-1:0] = core_sel[i];
            if (bus_addr == A_PIN_BASE + ADDR_W'(i)) begin
                bus_rdata[PIN_W-1:0]   = pin_num[i];
                bus_rdata[PIN_VLD_BIT] = pin_vld[i];
            end
        end
    end
endmodule

// File: rtl/shint_route.sv
module shint_route #(
    parameter int NUM_LINES = 16,
    parameter int NUM_CORES = 4,
    parameter int PIN_W     = 3,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_LINES-1:0]                active,
    input  logic [NUM_LINES-1:0][CORE_W-1:0]    core_sel,
    input  logic [NUM_LINES-1:0][PIN_W-1:0]     pin_num,
    input  logic [NUM_LINES-1:0]                pin_vld,
    output logic [NUM_CORES-1:0]                core_irq,
    output logic [NUM_CORES-1:0][(1<<PIN_W)-1:0] core_pin
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_LINES-1:0] hits;

        for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
            assign hits[i] = active[i] && (core_sel[i] == CORE_W'(c));
        end

        assign core_irq[c] = |hits;

        always_comb begin
            core_pin[c] = '0;
            for (int i = 0; i < NUM_LINES; i++)
                if (hits[i] && pin_vld[i])
                    core_pin[c][pin_num[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CORES = 4,
    parameter int PIN_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LINES-1:0]              line_in,
    input  logic                              bus_we,
    input  logic [7:0]                        bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic [NUM_CORES-1:0]              core_irq,
    output logic [NUM_CORES*(1<<PIN_W)-1:0]   core_pin
);
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int NPINS  = 1 << PIN_W;

    logic [NUM_LINES-1:0]             lvl, prev, pend, edge_q, mask_q;
    logic [NUM_LINES-1:0]             act_high, edge_mode, both;
    logic [NUM_LINES-1:0]             cmd_set, cmd_clr, pin_vld, active;
    logic [NUM_LINES-1:0][CORE_W-1:0] core_sel;
    logic [NUM_LINES-1:0][PIN_W-1:0]  pin_num;
    logic [NUM_CORES-1:0][NPINS-1:0]  pin_grid;

    shint_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .din(line_in), .lvl(lvl), .prev(prev)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lines
        line_cfg_t cfg;
        assign cfg = '{both: both[i], edge_mode: edge_mode[i], act_high: act_high[i]};

        shint_line u_line (
            .clk(clk), .rst(rst), .cfg(cfg), .lvl(lvl[i]), .prev(prev[i]),
            .cmd_set(cmd_set[i]), .cmd_clr(cmd_clr[i]),
            .pend(pend[i]), .edge_q(edge_q[i])
        );
    end

    shint_regs #(
        .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .PIN_W(PIN_W), .CORE_W(CORE_W)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend), .mask(mask_q),
        .act_high(act_high), .edge_mode(edge_mode), .both(both),
        .core_sel(core_sel), .pin_num(pin_num), .pin_vld(pin_vld),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr)
    );

    assign active = pend & mask_q;

    shint_route #(
        .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .PIN_W(PIN_W), .CORE_W(CORE_W)
    ) u_route (
        .active(active), .core_sel(core_sel), .pin_num(pin_num), .pin_vld(pin_vld),
        .core_irq(core_irq), .core_pin(pin_grid)
    );

    assign core_pin = pin_grid;
endmodule

// File: rtl/shint_ctrl_chk.sv
module shint_ctrl_chk #(
    parameter int NUM_LINES = 16,
    parameter int NUM_CORES = 4,
    parameter int PIN_W     = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            bus_we,
    input logic [7:0]                      bus_addr,
    input logic [31:0]                     bus_wdata,
    input logic [NUM_LINES-1:0]            mask_q,
    input logic [NUM_LINES-1:0]            edge_q,
    input logic [NUM_LINES-1:0]            cmd_clr,
    input logic [NUM_CORES-1:0]            core_irq,
    input logic [NUM_CORES*(1<<PIN_W)-1:0] core_pin
);
    localparam int NPINS = 1 << PIN_W;

    a_r1_mask_on_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h03) |=>
            ((mask_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    a_r2_mask_off_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h04) |=>
            ((mask_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (core_irq == '0));

    a_r7_latch_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(edge_q) & ~$past(cmd_clr) & ~edge_q) == '0));

    a_r8_masked_silent: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (core_irq == '0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_pin_chk
        a_r10_pin_implies_core: assert property (@(posedge clk) disable iff (rst)
            (core_pin[c*NPINS +: NPINS] != '0) |-> core_irq[c]);
    end
endmodule

bind shint_ctrl shint_ctrl_chk #(
    .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .PIN_W(PIN_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .edge_q(edge_q),
    .cmd_clr(cmd_clr), .core_irq(core_irq), .core_pin(core_pin)
);

// File: tb/shint_ctrl_bench.sv
module shint_ctrl_bench;
    localparam int N     = 16;
    localparam int C     = 4;
    localparam int PW    = 3;
    localparam int NPINS = 1 << PW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      line_in = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [C-1:0]      core_irq;
    logic [C*NPINS-1:0] core_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    shint_ctrl #(.NUM_LINES(N), .NUM_CORES(C), .PIN_W(PW)) u_shint_ctrl (
        .clk(clk), .rst(rst), .line_in(line_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_irq(core_irq), .core_pin(core_pin)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0] m_s1, m_s2, m_s3, m_ep, m_mask, m_hi, m_edge, m_both, m_pv;
    int m_core[N];
    int m_pin[N];

    function automatic bit m_pend(int i);
        if (m_edge[i]) return m_ep[i];
        return m_hi[i] ? m_s2[i] : !m_s2[i];
    endfunction

    function automatic logic [C-1:0] m_irq();
        logic [C-1:0] r = '0;
        for (int i = 0; i < N; i++)
            if (m_pend(i) && m_mask[i]) r[m_core[i]] = 1'b1;
        return r;
    endfunction

    function automatic logic [C*NPINS-1:0] m_pins();
        logic [C*NPINS-1:0] r = '0;
        for (int i = 0; i < N; i++)
            if (m_pend(i) && m_mask[i] && m_pv[i]) r[m_core[i]*NPINS + m_pin[i]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = 32'h0000_0301;
        else if (a == 8'h01) for (int i = 0; i < N; i++) r[i] = m_pend(i);
        else if (a == 8'h02) r[N-1:0] = m_mask;
        else if (a == 8'h05) r[N-1:0] = m_hi;
        else if (a == 8'h06) r[N-1:0] = m_edge;
        else if (a == 8'h07) r[N-1:0] = m_both;
        else if (a >= 8'h40 && a < 8'h40 + N) r = 32'(m_core[a - 8'h40]);
        else if (a >= 8'h80 && a < 8'h80 + N) r = {m_pv[a - 8'h80], 28'd0, 3'(m_pin[a - 8'h80])};
        return r;
    endfunction

    always @(posedge clk) begin
        bit [N-1:0] ep_n;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ep = '0; m_mask = '0;
            m_hi = '1; m_edge = '0; m_both = '0; m_pv = '0;
            for (int i = 0; i < N; i++) begin m_core[i] = 0; m_pin[i] = 0; end
        end else begin
            for (int i = 0; i < N; i++) begin
                bit det, setc, clrc;
                det = 0;
                if (m_edge[i]) begin
                    if (m_both[i]) det = (m_s2[i] != m_s3[i]);
                    else if (m_hi[i]) det = m_s2[i] && !m_s3[i];
                    else det = !m_s2[i] && m_s3[i];
                end
                setc = bus_we && bus_addr == 8'h08 && bus_wdata[31] && bus_wdata[7:0] == 8'(i);
                clrc = bus_we && bus_addr == 8'h08 && !bus_wdata[31] && bus_wdata[7:0] == 8'(i);
                ep_n[i] = clrc ? det : (m_ep[i] | det | setc);
            end
            m_ep = ep_n;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = line_in;
            if (bus_we) begin
                case (bus_addr)
                    8'h03: m_mask = m_mask | bus_wdata[N-1:0];
                    8'h04: m_mask = m_mask & ~bus_wdata[N-1:0];
                    8'h05: m_hi   = bus_wdata[N-1:0];
                    8'h06: m_edge = bus_wdata[N-1:0];
                    8'h07: m_both = bus_wdata[N-1:0];
                    default: ;
                endcase
                if (bus_addr >= 8'h40 && bus_addr < 8'h40 + N && int'(bus_wdata[1:0]) < C)
                    m_core[bus_addr - 8'h40] = int'(bus_wdata[1:0]);
                if (bus_addr >= 8'h80 && bus_addr < 8'h80 + N) begin
                    m_pin[bus_addr - 8'h80] = int'(bus_wdata[2:0]);
                    m_pv[bus_addr - 8'h80]  = 1'b1;
                end
            end
        end
    end

    // per-cycle comparison of the request outputs (R8, R10)
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            n_checks++;
            if (core_irq !== m_irq()) begin
                n_fail++;
                $display("FAIL R8 cycle compare core_irq actual=%b expected=%b", core_irq, m_irq());
            end
            n_checks++;
            if (core_pin !== m_pins()) begin
                n_fail++;
                $display("FAIL R10 cycle compare core_pin actual=%h expected=%h", core_pin, m_pins());
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
        chk({tag, " model"}, v, m_read(a));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int i, bit v);
        @(negedge clk);
        line_in[i] = v;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R3 / R11 reset state and capability word
        rd_chk("R11 caps", 8'h00, 32'h0000_0301);
        rd_chk("R3 act level", 8'h05, 32'h0000_FFFF);
        rd_chk("R3 trigger", 8'h06, 32'h0);
        rd_chk("R3 both edges", 8'h07, 32'h0);
        rd_chk("R3 mask", 8'h02, 32'h0);
        rd_chk("R3 core map", 8'h45, 32'h0);
        rd_chk("R3 pin map", 8'h85, 32'h0);
        chk("R3 core_irq", 32'(core_irq), 32'h0);

        // R1 / R2 mask set and clear
        wr(8'h03, 32'h0000_00FF);
        rd_chk("R1 mask on", 8'h02, 32'h0000_00FF);
        wr(8'h03, 32'h0);
        rd_chk("R1 zero no effect", 8'h02, 32'h0000_00FF);
        wr(8'h04, 32'h0000_000F);
        rd_chk("R2 mask off", 8'h02, 32'h0000_00F0);
        wr(8'h04, 32'h0);
        rd_chk("R2 zero no effect", 8'h02, 32'h0000_00F0);

        // R4 level line 4 routed to core 2 (R9)
        wr(8'h44, 32'd2);
        rd_chk("R9 core readback", 8'h44, 32'd2);
        set_line(4, 1);
        idle(3);
        chk("R4 level high pending", 32'(core_irq), 32'h4);
        rd_chk("R4 pend word", 8'h01, 32'h0000_0010);
        wr(8'h05, 32'h0000_FFEF);
        idle(1);
        chk("R4 active low, input high", 32'(core_irq), 32'h0);
        set_line(4, 0);
        idle(3);
        chk("R4 active low, input low", 32'(core_irq), 32'h4);
        wr(8'h05, 32'h0000_FFFF);
        idle(1);
        chk("R4 restored", 32'(core_irq), 32'h0);

        // R5 edge line 5 on core 1
        wr(8'h06, 32'h0000_00E0);
        wr(8'h45, 32'd1);
        set_line(5, 1);
        set_line(5, 0);
        idle(4);
        chk("R5 rising latched", 32'(core_irq), 32'h2);
        rd_chk("R5 pend word", 8'h01, 32'h0000_0020);
        wr(8'h08, 32'h0000_0005);
        chk("R7 clear", 32'(core_irq), 32'h0);
        wr(8'h05, 32'h0000_FFDF);
        set_line(5, 1);
        idle(4);
        chk("R5 active low ignores rise", 32'(core_irq), 32'h0);
        set_line(5, 0);
        idle(4);
        chk("R5 active low falling latched", 32'(core_irq), 32'h2);
        wr(8'h08, 32'h0000_0005);
        wr(8'h05, 32'h0000_FFFF);

        // R6 both edges on line 6 with active-low setting (ignored)
        wr(8'h07, 32'h0000_0040);
        wr(8'h05, 32'h0000_FFBF);
        set_line(6, 1);
        idle(4);
        chk("R6 rise latched", 32'(core_irq), 32'h1);
        wr(8'h08, 32'h0000_0006);
        chk("R6 cleared", 32'(core_irq), 32'h0);
        set_line(6, 0);
        idle(4);
        chk("R6 fall latched", 32'(core_irq), 32'h1);
        wr(8'h08, 32'h0000_0006);
        wr(8'h05, 32'h0000_FFFF);

        // R7 command injection and out of range
        wr(8'h08, 32'h8000_0007);
        rd_chk("R7 set inject", 8'h01, 32'h0000_0080);
        wr(8'h08, 32'h0000_0007);
        rd_chk("R7 clear ack", 8'h01, 32'h0);
        wr(8'h08, 32'h8000_0014);
        rd_chk("R7 out of range ignored", 8'h01, 32'h0);

        // R7 collision: edge detected on the same clock edge as a clear
        @(negedge clk); line_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0000_0005;
        @(negedge clk); bus_we = 1'b0;
        rd_chk("R7 detect wins over clear", 8'h01, 32'h0000_0020);
        set_line(5, 0);
        idle(4);
        wr(8'h08, 32'h0000_0005);

        // R9 reroute and R10 pin map
        wr(8'h08, 32'h8000_0005);
        chk("R9 on core 1", 32'(core_irq), 32'h2);
        wr(8'h45, 32'd3);
        chk("R9 moved to core 3", 32'(core_irq), 32'h8);
        chk("R10 invalid pin silent", core_pin, 32'h0);
        wr(8'h85, 32'h0000_0006);
        rd_chk("R10 valid forced", 8'h85, 32'h8000_0006);
        chk("R10 pin driven", core_pin, 32'h1 << (3*NPINS + 6));
        wr(8'h08, 32'h0000_0005);
        chk("R10 pin idle after clear", core_pin, 32'h0);

        // randomised mix, judged cycle by cycle against the model
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) line_in = N'($urandom);
            bus_we = 1'b0;
            if ($urandom_range(0, 2) == 0) begin
                int sel;
                logic [7:0] a;
                sel = $urandom_range(0, 7);
                case (sel)
                    0: a = 8'h03;
                    1: a = 8'h04;
                    2: a = 8'h05;
                    3: a = 8'h06;
                    4: a = 8'h07;
                    5: a = 8'h08;
                    6: a = 8'h40 + 8'($urandom_range(0, N-1));
                    default: a = 8'h80 + 8'($urandom_range(0, N-1));
                endcase
                bus_we = 1'b1;
                bus_addr = a;
                bus_wdata = (sel == 5) ? {1'($urandom), 23'd0, 8'($urandom_range(0, N+3))} : $urandom;
            end
            if ((k % 50) == 49) begin
                @(negedge clk);
                bus_we = 1'b0;
                bus_addr = 8'h01;
                #1 chk("R4 R5 R6 random pend", bus_rdata, m_read(8'h01));
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule